// File: doc/BRIEF.md
# Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames. The host writes a byte into a single holding register. When the shift engine is idle, the byte moves into an internal shift register that the host cannot reach. The engine then sends one frame: a low start bit, 5 to 8 data bits with bit 0 first, an optional parity bit and the stop period. The line rests high between frames.

Bit timing comes from an external strobe, `tick16`, that pulses once per sixteenth of a bit. Every bit lasts `OVS` strobes. The stop period can last one bit, one and a half bits or two bits. The framing inputs are sampled when a character moves from the holding register into the shift register, so a frame already on the line keeps its format.

Two flags pace the host. `thr_empty` shows that the holding register can accept another character. `tx_empty` shows that the holding register and the shift engine are both idle. A break input pulls the line low for as long as it is held.

Top module: `ser_tx_frame`

## Requirements
- R1: After reset, `txd` is 1, `thr_empty` is 1 and `tx_empty` is 1. While `tx_empty` is 1 and `brk` is 0, `txd` stays 1.
- R2: Each frame starts with a low start bit that lasts 16 ticks. The data bits follow, least significant bit first, 16 ticks each, and the line then goes high for the stop period.
- R3: `cfg_len` sets the character length: 0 = 5 bits, 1 = 6 bits, 2 = 7 bits, 3 = 8 bits. Only bits [len-1:0] of the written byte are sent. Higher bits affect neither the line nor the parity.
- R4: With `par_en`=1 and `par_stick`=0, a parity bit follows the data bits. With `par_even`=1 it makes the count of ones over data plus parity even. With `par_even`=0 it makes that count odd.
- R5: With `par_en`=1 and `par_stick`=1, the parity bit is constant: 1 when `par_even`=0 and 0 when `par_even`=1.
- R6: With `two_stop`=0 the stop period is 16 ticks. With `two_stop`=1 it is 24 ticks for 5-bit characters and 32 ticks for 6 to 8 bit characters.
- R7: A write (`wr_en`=1) clears `thr_empty` on the next cycle. `thr_empty` returns to 1 when the character moves into the shift register, while that frame is still being sent. A write while the holding register is full replaces the held character.
- R8: A character waiting in the holding register starts its frame as soon as the previous stop period ends. `tx_empty` rises only after the last stop period completes with nothing pending.
- R9: While `brk` is 1, `txd` is 0 from the next clock, whether the engine is idle or shifting. When `brk` is released, the line returns to the value the engine is driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| cfg_len | input | 2 | Character length code (0..3 = 5..8 bits) |
| two_stop | input | 1 | Long stop period select |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity, or stick-to-0 when stick is set |
| par_stick | input | 1 | Constant parity bit |
| brk | input | 1 | Force the line low |
| txd | output | 1 | Serial output, registered |
| thr_empty | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Nothing held and nothing shifting |

## Verification
The bench decodes frames at mid-bit for several lengths. It writes bytes with set high bits into short characters, so a design that leaked those bits would show a wrong stop bit or a flipped parity. It times two back-to-back all-ones frames from one start edge to the next in all four stop cases. A missing half-bit case, or an idle gap inserted between frames, changes that interval, and the bench also fails a `tx_empty` that pulses between the frames. Further tests cover stick parity against normal parity on the same byte, the overwrite of a full holding register, and a break applied in the middle of a run of ones.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_t;

  // Character length code offset: code 0 means this many bits
  localparam int MIN_CHAR_BITS = 5;

endpackage

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (wr_en) begin
        data <= wr_data;
        full <= 1'b1;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ser_tx_parity.sv
module ser_tx_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic [1:0]    len,
  input  logic          even,
  input  logic          stick,
  output logic          bit_o
);
  import ser_tx_pkg::*;

  logic [DW-1:0] masked;

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      masked[i] = data[i] & (i < (int'(len) + MIN_CHAR_BITS));
    end
  end

  always_comb begin
    if (stick)     bit_o = ~even;
    else if (even) bit_o = ^masked;
    else           bit_o = ~(^masked);
  end

endmodule

// File: rtl/ser_tx_engine.sv
module ser_tx_engine #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          pending,
  input  logic [DW-1:0] ld_data,
  input  logic [1:0]    len,
  input  logic          two_stop,
  input  logic          par_en,
  input  logic          par_bit,
  output logic          take,
  output logic          idle,
  output logic          line
);
  import ser_tx_pkg::*;

  localparam int CW = $clog2(2 * OVS) + 1;
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] BIT_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] STOP_ONE = CW'(OVS);
  localparam logic [CW-1:0] STOP_MID = CW'(OVS + OVS / 2);
  localparam logic [CW-1:0] STOP_TWO = CW'(2 * OVS);

  tx_state_t     state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] stop_lim;
  logic [CW-1:0] stop_sel;
  logic [IW-1:0] idx;
  logic [IW-1:0] last_idx;
  logic [DW-1:0] shreg;
  logic          par_q;
  logic          par_en_q;
  logic          line_q;

  assign take = (state == ST_IDLE) && pending;
  assign idle = (state == ST_IDLE);
  assign line = line_q;

  always_comb begin
    if (!two_stop)      stop_sel = STOP_ONE;
    else if (len == '0) stop_sel = STOP_MID;
    else                stop_sel = STOP_TWO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      stop_lim <= STOP_ONE;
      idx      <= '0;
      last_idx <= '0;
      shreg    <= '0;
      par_q    <= 1'b0;
      par_en_q <= 1'b0;
      line_q   <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          line_q <= 1'b1;
          if (take) begin
            state    <= ST_START;
            line_q   <= 1'b0;
            cnt      <= '0;
            shreg    <= ld_data;
            last_idx <= IW'(len) + IW'(MIN_CHAR_BITS - 1);
            par_q    <= par_bit;
            par_en_q <= par_en;
            stop_lim <= stop_sel;
          end
        end
        ST_START: begin
          if (tick) begin
            if (cnt == BIT_LAST) begin
              cnt    <= '0;
              idx    <= '0;
              state  <= ST_DATA;
              line_q <= shreg[0];
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (cnt == BIT_LAST) begin
              cnt <= '0;
              if (idx == last_idx) begin
                if (par_en_q) begin
                  state  <= ST_PAR;
                  line_q <= par_q;
                end else begin
                  state  <= ST_STOP;
                  line_q <= 1'b1;
                end
              end else begin
                idx    <= idx + 1'b1;
                shreg  <= shreg >> 1;
                line_q <= shreg[1];
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (tick) begin
            if (cnt == BIT_LAST) begin
              cnt    <= '0;
              state  <= ST_STOP;
              line_q <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (cnt == stop_lim - 1'b1) begin
              cnt   <= '0;
              state <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          state  <= ST_IDLE;
          line_q <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/ser_tx_frame.sv
module ser_tx_frame #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick16,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    cfg_len,
  input  logic          two_stop,
  input  logic          par_en,
  input  logic          par_even,
  input  logic          par_stick,
  input  logic          brk,
  output logic          txd,
  output logic          thr_empty,
  output logic          tx_empty
);

  logic          hold_full;
  logic [DW-1:0] hold_data;
  logic          take;
  logic          eng_idle;
  logic          eng_line;
  logic          par_bit;
  logic          txd_q;

  ser_tx_hold #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .full    (hold_full),
    .data    (hold_data)
  );

  ser_tx_parity #(.DW(DW)) u_par (
    .data  (hold_data),
    .len   (cfg_len),
    .even  (par_even),
    .stick (par_stick),
    .bit_o (par_bit)
  );

  ser_tx_engine #(.OVS(OVS), .DW(DW)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick16),
    .pending  (hold_full),
    .ld_data  (hold_data),
    .len      (cfg_len),
    .two_stop (two_stop),
    .par_en   (par_en),
    .par_bit  (par_bit),
    .take     (take),
    .idle     (eng_idle),
    .line     (eng_line)
  );

  always_ff @(posedge clk) begin
    if (rst) txd_q <= 1'b1;
    else     txd_q <= eng_line & ~brk;
  end

  assign txd       = txd_q;
  assign thr_empty = ~hold_full;
  assign tx_empty  = ~hold_full & eng_idle;

endmodule

// File: rtl/ser_tx_frame_chk.sv
module ser_tx_frame_chk (
  input logic clk,
  input logic rst,
  input logic brk,
  input logic wr_en,
  input logic txd,
  input logic thr_empty,
  input logic tx_empty,
  input logic take,
  input logic eng_idle,
  input logic eng_line
);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && !brk) |=> txd); // R1

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    take |=> (!eng_idle && !eng_line)); // R2

  AST_WRITE_FULL: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !thr_empty); // R7

  AST_XFER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(thr_empty) |-> !tx_empty); // R8

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    brk |=> !txd); // R9

endmodule

bind ser_tx_frame ser_tx_frame_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .brk       (brk),
  .wr_en     (wr_en),
  .txd       (txd),
  .thr_empty (thr_empty),
  .tx_empty  (tx_empty),
  .take      (take),
  .eng_idle  (eng_idle),
  .eng_line  (eng_line)
);

// File: tb/ser_tx_frame_tb.sv
module ser_tx_frame_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_len = 2'd3;
  logic       two_stop = 1'b0;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       par_stick = 1'b0;
  logic       brk = 1'b0;
  logic       txd, thr_empty, tx_empty;
  logic [1:0] tdiv = '0;
  logic       tick16;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int fall_prev = 0;
  int fall_last = 0;
  int nfall = 0;
  logic txd_prev = 1'b1;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= tdiv + 1'b1;
    cyc  <= cyc + 1;
  end
  assign tick16 = (tdiv == 2'd3);

  always @(negedge clk) begin
    if (txd_prev && !txd) begin
      fall_prev = fall_last;
      fall_last = cyc;
      nfall     = nfall + 1;
    end
    txd_prev = txd;
  end

  ser_tx_frame u_dut (
    .clk       (clk),
    .rst       (rst),
    .tick16    (tick16),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cfg_len   (cfg_len),
    .two_stop  (two_stop),
    .par_en    (par_en),
    .par_even  (par_even),
    .par_stick (par_stick),
    .brk       (brk),
    .txd       (txd),
    .thr_empty (thr_empty),
    .tx_empty  (tx_empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic ts, input logic pe,
                         input logic pv, input logic ps);
    @(negedge clk);
    cfg_len = l; two_stop = ts; par_en = pe; par_even = pv; par_stick = ps;
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!tick16) @(negedge clk);
    end
  endtask

  task automatic wait_cond_thr();
    for (int i = 0; i < 5000 && !thr_empty; i++) @(negedge clk);
  endtask

  task automatic wait_cond_temt();
    for (int i = 0; i < 5000 && !tx_empty; i++) @(negedge clk);
  endtask

  task automatic rx_frame(input int nbits, input bit has_par,
                          output logic [7:0] d, output logic p,
                          output logic st, output logic sp);
    d = '0; p = 1'b0;
    for (int i = 0; i < 5000 && txd; i++) @(negedge clk);
    wait_ticks(8);
    st = txd;
    for (int i = 0; i < nbits; i++) begin
      wait_ticks(16);
      d[i] = txd;
    end
    if (has_par) begin
      wait_ticks(16);
      p = txd;
    end
    wait_ticks(16);
    sp = txd;
  endtask

  task automatic t_reset();
    chk("R1 txd idle", int'(txd), 1);
    chk("R1 thr_empty", int'(thr_empty), 1);
    chk("R1 tx_empty", int'(tx_empty), 1);
  endtask

  task automatic t_basic();
    logic [7:0] d; logic p, st, sp;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    write_byte(8'hA5);
    rx_frame(8, 0, d, p, st, sp);
    chk("R2 start bit", int'(st), 0);
    chk("R2 data 8 bit", int'(d), 'hA5);
    chk("R2 stop bit", int'(sp), 1);
    wait_cond_temt();
    chk("R1 idle after frame", int'(txd), 1);
  endtask

  task automatic t_length();
    logic [7:0] d; logic p, st, sp;
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    write_byte(8'h0B);
    rx_frame(5, 0, d, p, st, sp);
    chk("R3 len5 data", int'(d), 'h0B);
    chk("R3 len5 stop after 5 bits", int'(sp), 1);
    wait_cond_temt();
    set_cfg(2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
    write_byte(8'h95);
    rx_frame(7, 1, d, p, st, sp);
    chk("R3 len7 data", int'(d), 'h15);
    chk("R3 len7 parity ignores bit7", int'(p), 1);
    chk("R3 len7 stop", int'(sp), 1);
    wait_cond_temt();
  endtask

  task automatic t_parity();
    logic [7:0] d; logic p, st, sp;
    set_cfg(2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    write_byte(8'h3C);
    rx_frame(8, 1, d, p, st, sp);
    chk("R4 odd parity", int'(p), 1);
    wait_cond_temt();
    set_cfg(2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
    write_byte(8'h3C);
    rx_frame(8, 1, d, p, st, sp);
    chk("R4 even parity", int'(p), 0);
    wait_cond_temt();
    set_cfg(2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    write_byte(8'h07);
    rx_frame(6, 1, d, p, st, sp);
    chk("R4 even parity len6", int'(p), 1);
    chk("R4 stop after parity", int'(sp), 1);
    wait_cond_temt();
  endtask

  task automatic t_stick();
    logic [7:0] d; logic p, st, sp;
    set_cfg(2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
    write_byte(8'h01);
    rx_frame(8, 1, d, p, st, sp);
    chk("R5 stick odd gives 1", int'(p), 1);
    wait_cond_temt();
    set_cfg(2'd3, 1'b0, 1'b1, 1'b1, 1'b1);
    write_byte(8'h01);
    rx_frame(8, 1, d, p, st, sp);
    chk("R5 stick even gives 0", int'(p), 0);
    wait_cond_temt();
  endtask

  task automatic t_stop(input logic [1:0] l, input logic ts, input int ticks, input string tag);
    int n0;
    set_cfg(l, ts, 1'b0, 1'b0, 1'b0);
    n0 = nfall;
    write_byte(8'hFF);
    wait_cond_thr();
    chk("R7 thr_empty during frame", int'(thr_empty), 1);
    chk("R7 tx_empty low during frame", int'(tx_empty), 0);
    write_byte(8'hFF);
    wait_cond_temt();
    chk("R8 no idle gap between frames", nfall - n0, 2);
    tests++;
    if ((fall_last - fall_prev) < ticks * 4 || (fall_last - fall_prev) > ticks * 4 + 8) begin
      fails++;
      $display("FAIL R6 %s: actual %0d cycles expected %0d..%0d", tag,
               fall_last - fall_prev, ticks * 4, ticks * 4 + 8);
    end
  endtask

  task automatic t_overwrite();
    logic [7:0] d; logic p, st, sp;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    write_byte(8'h11);
    wait_cond_thr();
    write_byte(8'h22);
    write_byte(8'h33);
    chk("R7 full after write", int'(thr_empty), 0);
    rx_frame(8, 0, d, p, st, sp);
    chk("R7 first frame", int'(d), 'h11);
    rx_frame(8, 0, d, p, st, sp);
    chk("R7 overwritten char sent", int'(d), 'h33);
    wait_cond_temt();
    chk("R8 empty at end", int'(tx_empty), 1);
  endtask

  task automatic t_break();
    @(negedge clk); brk = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 break while idle", int'(txd), 0);
    brk = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 release idle", int'(txd), 1);
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    write_byte(8'hFF);
    wait_ticks(40);
    chk("R9 data high before break", int'(txd), 1);
    brk = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 break while shifting", int'(txd), 0);
    brk = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 release shifting", int'(txd), 1);
    wait_cond_temt();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_length();
    t_parity();
    t_stick();
    t_stop(2'd0, 1'b0, 112, "len5 one stop");
    t_stop(2'd0, 1'b1, 120, "len5 one and a half stop");
    t_stop(2'd3, 1'b0, 160, "len8 one stop");
    t_stop(2'd3, 1'b1, 176, "len8 two stop");
    t_overwrite();
    t_break();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule